// File: doc/BRIEF.md
# Bus Region Decoder and Wait-State Timer

This block sits on the processor's external bus. When a bus cycle begins it sorts the address into one of four on-board regions: static RAM, boot ROM, the expansion bus and the system I/O window. It then raises the select for that region and holds it. Once the number of wait clocks set for that region has elapsed, it gives one ready pulse to close the cycle.

The wait for static RAM comes from two 2-bit configuration fields, one for reads and one for writes. The ROM always waits ten clocks. The expansion bus and the I/O window each use a fixed wait set by a parameter. The RAM and ROM windows each answer at a second, mirrored address that differs only in address bit 31. An address outside every window raises no select and never produces ready, so a separate bus timeout monitor can catch that cycle.

Top module: `region_wait_ctrl`

## Requirements
- R1: The RAM select is raised for addresses FE00_0000 to FE07_FFFF and for the mirror 7E00_0000 to 7E07_FFFF.
- R2: The ROM select is raised for addresses FFFC_0000 to FFFF_FFFF and for the mirror 7FFC_0000 to 7FFF_FFFF.
- R3: The expansion select is raised for 6010_0000 to 601F_FFFF, and the I/O select for 6100_0000 to 61FF_FFFF. These two windows have no mirror.
- R4: A cycle whose address falls in no window raises no select and no ready. The block then stays idle and accepts the next strobe.
- R5: A RAM read waits the number of clocks given by the read field: 00 gives 0, 01 gives 1, 10 gives 2 and 11 gives 3. The field is sampled with the strobe.
- R6: A RAM write (wr_i=1) takes its wait from the write field, with the same encoding. The read field has no effect on a write.
- R7: A ROM cycle waits ten clocks, whatever the value of either RAM field.
- R8: An expansion cycle waits XBUS_WAIT clocks (default 2), and an I/O cycle waits SYSIO_WAIT clocks (default 1).
- R9: A select rises in the clock after the strobe is sampled and stays steady until the ready clock. Ready is high for exactly one clock, and in the next clock every select is low.
- R10: A strobe that arrives while a cycle is open, including its ready clock, is ignored.
- R11: During reset, and after reset until the first strobe, no select and no ready are driven. With both fields at 11, which is their value before software programs them, a RAM cycle waits three clocks.
- R12: At most one select is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 32 | Processor address, sampled with the strobe |
| wr_i | input | 1 | 1 = write, 0 = read |
| strobe_i | input | 1 | Cycle-start pulse |
| sram_rd_wait_i | input | 2 | RAM read wait count, 0 to 3 |
| sram_wr_wait_i | input | 2 | RAM write wait count, 0 to 3 |
| sel_sram_o | output | 1 | RAM region select |
| sel_rom_o | output | 1 | ROM region select |
| sel_xbus_o | output | 1 | Expansion bus select |
| sel_sysio_o | output | 1 | System I/O select |
| ready_o | output | 1 | One-clock cycle-complete pulse |

## Verification
The strobe is sampled on a rising edge, and the select is due in the clock that follows that edge. Ready is due exactly W clocks later, where W is the wait for the region, so with W=0 ready shares its first clock with the select. The bench drives inputs and samples outputs on falling edges. After the strobe edge it counts the falling edges until ready appears and compares that count with W. It also checks the select at every one of those samples and confirms that everything is low one clock after ready. For unmapped addresses it watches twelve clocks and expects no select and no ready.

// File: rtl/rwc_pkg.sv
package rwc_pkg;
  localparam int ADDR_W = 32;
  localparam int N_REG  = 4;

  typedef enum logic [1:0] {
    REG_SRAM  = 2'd0,
    REG_ROM   = 2'd1,
    REG_XBUS  = 2'd2,
    REG_SYSIO = 2'd3
  } region_e;

  // index order: {SYSIO, XBUS, ROM, SRAM}; bit 31 dropped from RAM/ROM masks gives the mirrors
  localparam logic [N_REG-1:0][ADDR_W-1:0] REG_MASK = {
    32'hFF00_0000, 32'hFFF0_0000, 32'h7FFC_0000, 32'h7FF8_0000
  };
  localparam logic [N_REG-1:0][ADDR_W-1:0] REG_MATCH = {
    32'h6100_0000, 32'h6010_0000, 32'h7FFC_0000, 32'h7E00_0000
  };
endpackage

// File: rtl/rwc_region_dec.sv
module rwc_region_dec
  import rwc_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output logic [N_REG-1:0]  hit_o
);
  for (genvar g = 0; g < N_REG; g++) begin : g_win
    assign hit_o[g] = (addr_i & REG_MASK[g]) == REG_MATCH[g];
  end
endmodule

// File: rtl/rwc_wait_sel.sv
module rwc_wait_sel
  import rwc_pkg::*;
#(
  parameter int CNT_W      = 4,
  parameter int ROM_WAIT   = 10,
  parameter int XBUS_WAIT  = 2,
  parameter int SYSIO_WAIT = 1
) (
  input  logic [N_REG-1:0] hit_i,
  input  logic             wr_i,
  input  logic [1:0]       rd_cfg_i,
  input  logic [1:0]       wr_cfg_i,
  output logic [CNT_W-1:0] wait_o
);
  always_comb begin
    wait_o = '0;
    if (hit_i[REG_SRAM])       wait_o = CNT_W'(wr_i ? wr_cfg_i : rd_cfg_i);
    else if (hit_i[REG_ROM])   wait_o = CNT_W'(ROM_WAIT);
    else if (hit_i[REG_XBUS])  wait_o = CNT_W'(XBUS_WAIT);
    else if (hit_i[REG_SYSIO]) wait_o = CNT_W'(SYSIO_WAIT);
  end
endmodule

// File: rtl/rwc_wait_ctr.sv
module rwc_wait_ctr
  import rwc_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_i,
  input  logic [N_REG-1:0] hit_i,
  input  logic [CNT_W-1:0] load_i,
  output logic [N_REG-1:0] sel_o,
  output logic             ready_o
);
  logic [N_REG-1:0] sel_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy;

  assign busy    = |sel_q;
  assign ready_o = busy && (cnt_q == '0);
  assign sel_o   = sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      cnt_q <= '0;
    end else if (ready_o) begin
      sel_q <= '0;
    end else if (busy) begin
      cnt_q <= cnt_q - 1'b1;
    end else if (strobe_i) begin
      sel_q <= hit_i;  // all-zero for unmapped: stays idle
      cnt_q <= load_i;
    end
  end
endmodule

// File: rtl/region_wait_ctrl.sv
module region_wait_ctrl
  import rwc_pkg::*;
#(
  parameter int ROM_WAIT   = 10,
  parameter int XBUS_WAIT  = 2,
  parameter int SYSIO_WAIT = 1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] addr_i,
  input  logic        wr_i,
  input  logic        strobe_i,
  input  logic [1:0]  sram_rd_wait_i,
  input  logic [1:0]  sram_wr_wait_i,
  output logic        sel_sram_o,
  output logic        sel_rom_o,
  output logic        sel_xbus_o,
  output logic        sel_sysio_o,
  output logic        ready_o
);
  localparam int MAX_A = (ROM_WAIT > XBUS_WAIT) ? ROM_WAIT : XBUS_WAIT;
  localparam int MAX_B = (SYSIO_WAIT > 3) ? SYSIO_WAIT : 3;
  localparam int MAX_W = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAX_W + 1);

  logic [N_REG-1:0] hit, sel;
  logic [CNT_W-1:0] wait_cnt;

  rwc_region_dec u_dec (
    .addr_i (addr_i),
    .hit_o  (hit)
  );

  rwc_wait_sel #(
    .CNT_W      (CNT_W),
    .ROM_WAIT   (ROM_WAIT),
    .XBUS_WAIT  (XBUS_WAIT),
    .SYSIO_WAIT (SYSIO_WAIT)
  ) u_wsel (
    .hit_i    (hit),
    .wr_i     (wr_i),
    .rd_cfg_i (sram_rd_wait_i),
    .wr_cfg_i (sram_wr_wait_i),
    .wait_o   (wait_cnt)
  );

  rwc_wait_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (strobe_i),
    .hit_i    (hit),
    .load_i   (wait_cnt),
    .sel_o    (sel),
    .ready_o  (ready_o)
  );

  assign sel_sram_o  = sel[REG_SRAM];
  assign sel_rom_o   = sel[REG_ROM];
  assign sel_xbus_o  = sel[REG_XBUS];
  assign sel_sysio_o = sel[REG_SYSIO];
endmodule

// File: rtl/rwc_checker.sv
module rwc_checker #(
  parameter int ROM_WAIT   = 10,
  parameter int XBUS_WAIT  = 2,
  parameter int SYSIO_WAIT = 1
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       strobe_i,
  input logic       wr_i,
  input logic [1:0] sram_rd_wait_i,
  input logic [1:0] sram_wr_wait_i,
  input logic       sel_sram_o,
  input logic       sel_rom_o,
  input logic       sel_xbus_o,
  input logic       sel_sysio_o,
  input logic       ready_o
);
  logic [3:0] sels;
  logic       any_sel;
  logic [7:0] held_q;
  logic [1:0] sram_exp_q;

  assign sels    = {sel_sysio_o, sel_xbus_o, sel_rom_o, sel_sram_o};
  assign any_sel = |sels;

  // clocks a select has been held before ready
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q     <= '0;
      sram_exp_q <= 2'b11;
    end else begin
      if (ready_o || !any_sel) held_q <= '0;
      else                     held_q <= held_q + 1'b1;
      if (strobe_i && !any_sel) sram_exp_q <= wr_i ? sram_wr_wait_i : sram_rd_wait_i;
    end
  end

  p_onehot_sel_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sels));
  p_ready_has_sel_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> any_sel);
  p_ready_closes_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !any_sel && !ready_o);
  p_sel_steady_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_sel && !ready_o) |=> $stable(sels));
  p_sel_needs_strobe_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(any_sel) |-> $past(strobe_i));
  p_rom_wait_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && sel_rom_o) |-> (int'(held_q) == ROM_WAIT));
  p_sram_wait_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && sel_sram_o) |-> (held_q == {6'd0, sram_exp_q}));
  p_xbus_wait_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && sel_xbus_o) |-> (int'(held_q) == XBUS_WAIT));
  p_sysio_wait_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && sel_sysio_o) |-> (int'(held_q) == SYSIO_WAIT));
endmodule

bind region_wait_ctrl rwc_checker #(
  .ROM_WAIT   (ROM_WAIT),
  .XBUS_WAIT  (XBUS_WAIT),
  .SYSIO_WAIT (SYSIO_WAIT)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .strobe_i       (strobe_i),
  .wr_i           (wr_i),
  .sram_rd_wait_i (sram_rd_wait_i),
  .sram_wr_wait_i (sram_wr_wait_i),
  .sel_sram_o     (sel_sram_o),
  .sel_rom_o      (sel_rom_o),
  .sel_xbus_o     (sel_xbus_o),
  .sel_sysio_o    (sel_sysio_o),
  .ready_o        (ready_o)
);

// File: tb/region_wait_ctrl_tb.sv
module region_wait_ctrl_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] addr_i = '0;
  logic        wr_i = 1'b0;
  logic        strobe_i = 1'b0;
  logic [1:0]  sram_rd_wait_i = 2'b11;
  logic [1:0]  sram_wr_wait_i = 2'b11;
  logic        sel_sram_o, sel_rom_o, sel_xbus_o, sel_sysio_o, ready_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk_i = ~clk_i;

  region_wait_ctrl u_dut (.*);

  wire [3:0] sels = {sel_sysio_o, sel_xbus_o, sel_rom_o, sel_sram_o};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // idx: 0 sram,1 rom,2 xbus,3 sysio,-1 unmapped. inj>=0: stray strobe at that wait clock
  task automatic run(input logic [31:0] a, input logic w, input logic [1:0] rc, input logic [1:0] wc,
                     input int idx, input int exp_w, input string req, input int inj = -1);
    int  n = 0;
    bit  sel_ok = 1;
    bit  done = 0;
    @(negedge clk_i);
    addr_i = a; wr_i = w; sram_rd_wait_i = rc; sram_wr_wait_i = wc; strobe_i = 1'b1;
    @(negedge clk_i);
    strobe_i = 1'b0;
    if (idx < 0) begin
      for (int i = 0; i < 12; i++) begin
        if (sels != 4'd0 || ready_o) sel_ok = 0;
        @(negedge clk_i);
      end
      check(sel_ok, {req, " R4 unmapped quiet"}, int'(sels), 0);
      return;
    end
    for (int i = 0; i < 20 && !done; i++) begin
      if (sels != (4'b1 << idx)) sel_ok = 0;
      if (ready_o) done = 1;
      else begin
        if (i == inj) begin addr_i = 32'hFE00_0000; strobe_i = 1'b1; end
        n++;
        @(negedge clk_i);
        strobe_i = 1'b0;
      end
    end
    check(sel_ok, {req, " select"}, int'(sels), 1 << idx);
    check(done && n == exp_w, {req, " wait count"}, n, exp_w);
    @(negedge clk_i);
    check(sels == 4'd0 && !ready_o, {req, " R9 closes after ready"}, int'({sels, ready_o}), 0);
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    strobe_i = 1'b1; addr_i = 32'hFE00_0000;
    @(negedge clk_i);
    check(sels == 4'd0 && !ready_o, "R11 quiet in reset", int'(sels), 0);
    strobe_i = 1'b0;
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check(sels == 4'd0 && !ready_o, "R11 idle after reset", int'(sels), 0);
    run(32'hFE00_0100, 1'b0, 2'b11, 2'b11, 0, 3, "R11 default fields");

    // R5/R6: every read and write field pair, both RAM windows, both ends
    for (int m = 0; m < 2; m++)
      for (int rc = 0; rc < 4; rc++)
        for (int wc = 0; wc < 4; wc++) begin
          logic [31:0] base = (m == 0) ? 32'hFE00_0000 : 32'h7E00_0000;
          run(base, 1'b0, 2'(rc), 2'(wc), 0, rc, "R5 R1 sram read");
          run(base | 32'h0007_FFFC, 1'b1, 2'(rc), 2'(wc), 0, wc, "R6 R1 sram write");
        end

    // R7/R2: ROM ignores RAM fields
    for (int rc = 0; rc < 4; rc++) begin
      run(32'hFFFC_0000, 1'b0, 2'(rc), 2'(3 - rc), 1, 10, "R7 R2 rom");
      run(32'h7FFF_FFFC, 1'b1, 2'(rc), 2'(rc), 1, 10, "R7 R2 rom mirror");
    end

    // R3/R8
    run(32'h6010_0000, 1'b0, 2'b00, 2'b00, 2, 2, "R3 R8 xbus low");
    run(32'h601F_FFFC, 1'b1, 2'b11, 2'b11, 2, 2, "R3 R8 xbus high");
    run(32'h6100_0000, 1'b0, 2'b00, 2'b00, 3, 1, "R3 R8 sysio low");
    run(32'h61FF_FFFC, 1'b1, 2'b11, 2'b11, 3, 1, "R3 R8 sysio high");

    // R4: just outside each window, and non-mirrored windows at bit31 set
    run(32'hFDFF_FFFC, 1'b0, 2'b00, 2'b00, -1, 0, "R4 below sram");
    run(32'hFE08_0000, 1'b0, 2'b00, 2'b00, -1, 0, "R4 above sram");
    run(32'h7E08_0000, 1'b0, 2'b00, 2'b00, -1, 0, "R4 above sram mirror");
    run(32'hFFFB_FFFC, 1'b0, 2'b00, 2'b00, -1, 0, "R4 below rom");
    run(32'h600F_FFFC, 1'b0, 2'b00, 2'b00, -1, 0, "R4 below xbus");
    run(32'h6020_0000, 1'b0, 2'b00, 2'b00, -1, 0, "R4 above xbus");
    run(32'h60FF_FFFC, 1'b0, 2'b00, 2'b00, -1, 0, "R4 below sysio");
    run(32'h6200_0000, 1'b0, 2'b00, 2'b00, -1, 0, "R4 above sysio");
    run(32'hE100_0000, 1'b0, 2'b00, 2'b00, -1, 0, "R4 sysio no mirror");
    run(32'h0000_0000, 1'b0, 2'b00, 2'b00, -1, 0, "R4 zero");
    run(32'hFE00_0000, 1'b0, 2'b01, 2'b00, 0, 1, "R4 accepts next strobe");

    // R10: stray strobe during an open ROM cycle
    run(32'hFFFC_0040, 1'b0, 2'b00, 2'b00, 1, 10, "R10 stray strobe ignored", 3);
    run(32'h7FFC_0000, 1'b0, 2'b00, 2'b00, 1, 10, "R10 stray strobe at last wait", 9);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule